// File: doc/BRIEF.md
# Offset-Addressed Event Commit Buffer

This block sits between a data generator and a sequential consumer. The generator builds one event at a time by writing 32-bit words to any word position inside the event, in any order. It then closes the event with a single-cycle commit pulse that carries the event length in words. Only after that commit does the event become visible on the read side. The read side then streams the words from position 0 up to length-1 over a valid/ready handshake and flags the final word.

Two storage slots give double buffering. While one committed event drains, the generator fills the other slot. If a second event is committed before the first has drained, the generator is told to wait: the free indication drops until the drain completes.

A synchronous clear input empties the buffer, and a one-cycle reset indication informs the generator. Malformed or refused commits are dropped and tallied in a saturating error counter.

Top module: `evbuf_commit`

## Requirements
- R1: A word written with `ev_wr` high at position `ev_off` is stored at that position in that cycle. After an accepted commit of length L, the read port presents positions 0..L-1 in ascending order, whatever order the writes came in.
- R2: `rd_valid` rises in the cycle after an accepted commit. `rd_last` is high only on position L-1. A word is consumed on a cycle where `rd_valid` and `rd_ready` are both high. After the last word is consumed with nothing pending, `rd_valid` is low.
- R3: A commit with length 0 or a length above `MAX_WORDS` is dropped. It changes no read-side state and raises `err_cnt` by one. `err_cnt` saturates at its all-ones value.
- R4: Writes at a position at or above `MAX_WORDS` are ignored and alter no stored word.
- R5: `ev_free` is high after reset and stays high while exactly one committed event drains. It goes low in the cycle after a second event is committed during a drain. It goes high again in the cycle after the last word of the draining event is consumed. At that point the waiting event is presented without a gap.
- R6: A commit while `ev_free` is low, because an event is waiting, is dropped and counted in `err_cnt` like R3.
- R7: In the cycle after `buf_clr` is high, `ev_rst` is high for exactly one cycle, `rd_valid` is low and `ev_free` is low. In the cycle after that, `ev_free` is high.
- R8: Each accepted commit takes the slot the generator was filling, and the generator moves to the other slot; a clear does not change which slot is being filled. A position below L that was not written since the previous use of that slot reads out the word written there by the event accepted two commits earlier.
- R9: While `rd_valid` is high and `rd_ready` low, `rd_valid` stays high and `rd_data` holds its value.
- R10: Writes while an event is waiting (`ev_free` low after a second commit) are ignored and do not alter the waiting event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_clr | input | 1 | Synchronous buffer clear |
| ev_word | input | DATA_W | Word to store |
| ev_off | input | OFF_W | Word position inside the event |
| ev_wr | input | 1 | Store `ev_word` this cycle |
| ev_len | input | OFF_W | Length in words of the event being committed |
| ev_commit | input | 1 | Commit the event this cycle |
| ev_free | output | 1 | Space exists to build a new event |
| ev_rst | output | 1 | One-cycle pulse: buffer was cleared |
| rd_valid | output | 1 | A committed word is presented |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_data | output | DATA_W | Presented word |
| rd_last | output | 1 | Presented word is the final one of the event |
| err_cnt | output | ERR_W | Saturating count of dropped commits |

## Verification
Storage writes and commits take effect at the clock edge on which they are driven. The read data is a combinational look-up of the current slot and pointer. Therefore `rd_valid`, `rd_data`, `rd_last`, `ev_free` and `err_cnt` all show their new values one edge after the stimulus, and `ev_rst` shows its new value one edge after `buf_clr`. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. During stalled reads it samples twice around an edge with `rd_ready` low to confirm the held word. A sweep over every event length of a 12-word configuration writes positions in an interleaved end-to-middle order. Expected words come from a bench-side model of the two slots that alternates on each accepted commit.

// File: rtl/evbuf_commit.sv
module evbuf_commit #(
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 11,
  parameter int MAX_WORDS = 1500,
  parameter int ERR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr,
  input  logic [DATA_W-1:0] ev_word,
  input  logic [OFF_W-1:0]  ev_off,
  input  logic              ev_wr,
  input  logic [OFF_W-1:0]  ev_len,
  input  logic              ev_commit,
  output logic              ev_free,
  output logic              ev_rst,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic [ERR_W-1:0]  err_cnt
);
  localparam logic [OFF_W:0] MAXV = (OFF_W+1)'(MAX_WORDS);

  logic [DATA_W-1:0] mem [2][MAX_WORDS];
  logic              wsel, rsel, busy, pend, rst_p;
  logic [OFF_W-1:0]  rptr, rlen, plen;

  wire len_ok = (ev_len != '0) && ({1'b0, ev_len} <= MAXV);
  wire off_ok = {1'b0, ev_off} < MAXV;
  wire acc    = ev_commit && len_ok && !pend;
  wire bad    = ev_commit && !(len_ok && !pend);
  wire take   = busy && rd_ready;
  wire done   = take && rd_last;

  assign ev_free  = !pend && !rst_p;
  assign ev_rst   = rst_p;
  assign rd_valid = busy;
  assign rd_last  = busy && (rptr == rlen - 1'b1);
  assign rd_data  = mem[rsel][rptr];

  always_ff @(posedge clk)
    if (ev_wr && off_ok && !pend) mem[wsel][ev_off] <= ev_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; pend <= 1'b0; rst_p <= 1'b0;
      wsel <= 1'b0; rsel <= 1'b0;
      rptr <= '0; rlen <= '0; plen <= '0;
      err_cnt <= '0;
    end else if (buf_clr) begin
      busy  <= 1'b0;
      pend  <= 1'b0;
      rst_p <= 1'b1;
      rptr  <= '0;
    end else begin
      rst_p <= 1'b0;
      if (bad && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
      if (take && !rd_last) rptr <= rptr + 1'b1;
      if (acc) begin
        if (!busy || done) begin
          busy <= 1'b1;
          rsel <= wsel;
          rlen <= ev_len;
          rptr <= '0;
          wsel <= !wsel;
        end else begin
          pend <= 1'b1;
          plen <= ev_len;
        end
      end else if (done) begin
        rptr <= '0;
        if (pend) begin
          rsel <= wsel;
          rlen <= plen;
          pend <= 1'b0;
          wsel <= !wsel;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end
endmodule

module evbuf_commit_chk #(
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 11,
  parameter int MAX_WORDS = 1500,
  parameter int ERR_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              buf_clr,
  input logic [OFF_W-1:0]  ev_len,
  input logic              ev_commit,
  input logic              ev_free,
  input logic              ev_rst,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_last,
  input logic [ERR_W-1:0]  err_cnt
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !buf_clr |=> rd_valid && $stable(rd_data));

  // R7
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clr |=> ev_rst && !rd_valid && !ev_free);

  // R7
  clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rst && !buf_clr |=> !ev_rst && ev_free);

  // R3
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit && ev_len == '0 && !buf_clr |=>
      err_cnt == (($past(err_cnt) == '1) ? $past(err_cnt) : $past(err_cnt) + 1'b1));

  // R6
  busy_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit && !ev_free && !ev_rst && !buf_clr |=>
      err_cnt == (($past(err_cnt) == '1) ? $past(err_cnt) : $past(err_cnt) + 1'b1));

  // R5
  wait_implies_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_free && !ev_rst |-> rd_valid);

  // R2
  last_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R2
  mid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !rd_last && !buf_clr |=> rd_valid);
endmodule

bind evbuf_commit evbuf_commit_chk #(
  .DATA_W(DATA_W), .OFF_W(OFF_W), .MAX_WORDS(MAX_WORDS), .ERR_W(ERR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .ev_len(ev_len),
  .ev_commit(ev_commit), .ev_free(ev_free), .ev_rst(ev_rst),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_last(rd_last), .err_cnt(err_cnt)
);

// File: tb/evbuf_commit_tb_top.sv
module evbuf_commit_tb_top;
  localparam int DW = 32, OW = 4, MW = 12, EW = 3;

  logic clk = 1'b0, rst_n = 1'b0, buf_clr = 1'b0;
  logic [DW-1:0] ev_word = '0;
  logic [OW-1:0] ev_off = '0, ev_len = '0;
  logic ev_wr = 1'b0, ev_commit = 1'b0, rd_ready = 1'b0;
  logic ev_free, ev_rst, rd_valid, rd_last;
  logic [DW-1:0] rd_data;
  logic [EW-1:0] err_cnt;

  evbuf_commit #(.DATA_W(DW), .OFF_W(OW), .MAX_WORDS(MW), .ERR_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .ev_word(ev_word),
    .ev_off(ev_off), .ev_wr(ev_wr), .ev_len(ev_len), .ev_commit(ev_commit),
    .ev_free(ev_free), .ev_rst(ev_rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last), .err_cnt(err_cnt));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, experr = 0, ms = 0;
  logic [DW-1:0] mdl [2][MW];
  bit finished = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(int off, logic [DW-1:0] d, bit keep);
    ev_wr = 1'b1; ev_off = OW'(off); ev_word = d;
    @(negedge clk);
    ev_wr = 1'b0;
    if (keep && off < MW) mdl[ms][off] = d;
  endtask

  task automatic commit(int len);
    ev_commit = 1'b1; ev_len = OW'(len);
    @(negedge clk);
    ev_commit = 1'b0;
  endtask

  task automatic bump_err();
    experr = (experr == 7) ? 7 : experr + 1;
  endtask

  task automatic drain(int slot, int len, bit stall, string req);
    for (int i = 0; i < len; i++) begin
      if (stall && (i % 2 == 1)) begin
        rd_ready = 1'b0;
        @(negedge clk);
        chk("R9", {31'd0, rd_valid}, 1);
        chk("R9", rd_data, mdl[slot][i]);
      end
      rd_ready = 1'b1;
      chk(req, {31'd0, rd_valid}, 1);
      chk(req, rd_data, mdl[slot][i]);
      chk("R2", {31'd0, rd_last}, (i == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset free", {31'd0, ev_free}, 1);
    chk("R2 reset valid", {31'd0, rd_valid}, 0);
    chk("R7 reset ind", {31'd0, ev_rst}, 0);
    chk("R3 reset err", {29'd0, err_cnt}, 0);

    // R1 R2 R9: every length, interleaved write order
    for (int len = 1; len <= MW; len++) begin
      int slot;
      for (int k = 0; k < len; k++) begin
        int off;
        off = (k % 2 == 0) ? (len - 1 - k / 2) : (k / 2);
        wr(off, 32'hA000_0000 | (len << 12) | (off << 4) | (k & 15), 1);
      end
      commit(len);
      slot = ms; ms ^= 1;
      chk("R5 free one drain", {31'd0, ev_free}, 1);
      drain(slot, len, len % 2 == 1, "R1");
      chk("R2 empty after drain", {31'd0, rd_valid}, 0);
    end

    // R4: out-of-range positions ignored
    begin
      int slot;
      for (int o = 0; o < MW; o++) wr(o, 32'hB000_0000 + o, 1);
      for (int o = MW; o < 16; o++) wr(o, 32'hDEAD_0000 + o, 1);
      commit(MW);
      slot = ms; ms ^= 1;
      drain(slot, MW, 0, "R4");
    end

    // R8: unwritten positions keep the word from two events earlier
    begin
      int slot;
      wr(0, 32'hC000_0000, 1);
      wr(5, 32'hC000_0005, 1);
      commit(8);
      slot = ms; ms ^= 1;
      drain(slot, 8, 0, "R8");
    end

    // R5 R6 R10: second commit while first drains
    begin
      int s1, s2;
      for (int o = 0; o < 3; o++) wr(o, 32'hD100_0000 + o, 1);
      commit(3);
      s1 = ms; ms ^= 1;
      chk("R5 free while one drains", {31'd0, ev_free}, 1);
      wr(0, 32'hD200_0000, 1);
      wr(1, 32'hD200_0001, 1);
      commit(2);
      s2 = ms; ms ^= 1;
      chk("R5 free low when waiting", {31'd0, ev_free}, 0);
      wr(0, 32'hEEEE_EEEE, 0);
      commit(2); bump_err();
      chk("R6 refused commit counted", {29'd0, err_cnt}, experr);
      chk("R5 still waiting", {31'd0, ev_free}, 0);
      drain(s1, 3, 1, "R5");
      chk("R5 free after drain", {31'd0, ev_free}, 1);
      drain(s2, 2, 0, "R10");
      chk("R2 empty after second", {31'd0, rd_valid}, 0);
    end

    // R7: clear
    begin
      int s;
      wr(0, 32'hF000_0000, 1);
      wr(1, 32'hF000_0001, 1);
      commit(2); ms ^= 1;
      chk("R2 visible after commit", {31'd0, rd_valid}, 1);
      buf_clr = 1'b1;
      @(negedge clk);
      buf_clr = 1'b0;
      chk("R7 ind", {31'd0, ev_rst}, 1);
      chk("R7 empty", {31'd0, rd_valid}, 0);
      chk("R7 free low", {31'd0, ev_free}, 0);
      @(negedge clk);
      chk("R7 ind single", {31'd0, ev_rst}, 0);
      chk("R7 free high", {31'd0, ev_free}, 1);
      chk("R7 still empty", {31'd0, rd_valid}, 0);
      wr(0, 32'h1234_5678, 1);
      commit(1);
      s = ms; ms ^= 1;
      drain(s, 1, 0, "R7 after clear");
    end

    // R3: bad lengths, saturation
    commit(0); bump_err();
    chk("R3 zero len", {29'd0, err_cnt}, experr);
    chk("R3 zero len no event", {31'd0, rd_valid}, 0);
    commit(MW + 1); bump_err();
    chk("R3 over len", {29'd0, err_cnt}, experr);
    chk("R3 over len no event", {31'd0, rd_valid}, 0);
    for (int n = 0; n < 8; n++) begin
      commit(15); bump_err();
      chk("R3 saturate", {29'd0, err_cnt}, experr);
    end
    chk("R3 free unchanged", {31'd0, ev_free}, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule